// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block provides sixteen general-purpose I/O lines with a per-line interrupt detector, all programmed over a small single-cycle register bus. Each line can drive a value or act as an input, and the pad level of every line is always sampled and readable whatever its direction. Every line owns a 3-bit style code that selects the condition reported as an interrupt. The codes are packed eight to a register across two style registers.

Detected events set a sticky pending bit per line. That bit is driven straight onto a dedicated interrupt output for the line. Software clears a pending bit by writing 1 to it. A line programmed for a level condition keeps raising its pending bit for as long as the condition holds, so a clear only takes effect once the level has gone away.

Pad inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with a copy delayed by one cycle. The external reset is asserted asynchronously and released through a two-flop synchroniser.

Top module: `gpio_irq_style_unit`

Register map (3-bit `bus_addr`, read data is combinational from the address, unused bits read 0):

| Address | Register |
|---|---|
| 0 | direction: bit i = 1 means line i is an input |
| 1 | output data |
| 2 | synchronised input level (read only) |
| 3 | styles of lines 0 to 7, line i at bits 3i+2:3i |
| 4 | styles of lines 8 to 15, line i at bits 3(i-8)+2:3(i-8) |
| 5 | pending status (write 1 to clear) |

## Requirements
- R1: After reset, the direction register reads 16'hFFFF, `pad_oe` and `pad_out` are 0, both style registers read 32'h00FFFFFF (every field code 7), and `irq` is 0.
- R2: `pad_oe[i]` is the inverse of direction bit i, `pad_out` equals the output data register, and both registers read back their 16 low bits with the upper bits 0.
- R3: Address 2 returns each pad level two clock edges after it is applied, and still returns the old level after one edge.
- R4: A line's style field sits in register 3 (lines 0 to 7) or register 4 (lines 8 to 15) at bit offset 3*(line mod 8). Only bits 23:0 of each style register are kept.
- R5: Code 0 flags a line while its synchronised level is 1. Code 1 flags it while the level is 0.
- R6: Code 2 flags a 0-to-1 change of the synchronised level. Code 3 flags a 1-to-0 change.
- R7: Code 4 flags a change of the synchronised level in either direction.
- R8: Codes 5, 6 and 7 never flag the line.
- R9: Writing to address 5 clears each pending bit written as 1, unless that line is flagged in the same cycle. Bits written as 0 are left unchanged.
- R10: A line under a level style whose condition still holds stays pending through a clear.
- R11: Rewriting a line's style leaves its pending bit unchanged.
- R12: `irq[i]` is the pending bit of line i. It stays set until cleared, and address 5 reads the same vector.
- R13: A pad change is seen on `irq` at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 16 | Pad levels, asynchronous |
| pad_out | output | 16 | Output data to the pads |
| pad_oe | output | 16 | Pad drive enable, 1 = drive |
| irq | output | 16 | Per-line pending interrupt |

## Verification
A wrong style decode or a misplaced style field appears on `irq` as a bit that rises on the wrong transition, stays low on the right one, or rises on a neighbouring line. This shows up within three clock edges of the pad change, so every code is swept on every line with rising and falling stimulus. Faults in the pending logic surface at the write that should clear it: a clear that fails to take, a 0 that clears, or a level line that drops while its condition holds. A synchroniser with the wrong depth shifts the first cycle in which `irq` and the input register change, so both are sampled on each side of the expected edge.

// File: rtl/gpio_style_pkg.sv
package gpio_style_pkg;
  localparam int BUS_AW = 3;

  localparam logic [BUS_AW-1:0] A_DIR  = 3'd0;
  localparam logic [BUS_AW-1:0] A_DOUT = 3'd1;
  localparam logic [BUS_AW-1:0] A_DIN  = 3'd2;
  localparam logic [BUS_AW-1:0] A_STY0 = 3'd3;
  localparam logic [BUS_AW-1:0] A_STY1 = 3'd4;
  localparam logic [BUS_AW-1:0] A_STAT = 3'd5;

  localparam logic [2:0] STY_HIGH = 3'd0;
  localparam logic [2:0] STY_LOW  = 3'd1;
  localparam logic [2:0] STY_RISE = 3'd2;
  localparam logic [2:0] STY_FALL = 3'd3;
  localparam logic [2:0] STY_BOTH = 3'd4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] lvl_cur,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;

  // Two synchronising stages, then one delay stage for edge compare.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl_cur  <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= pad_in;
      lvl_cur  <= meta_q;
      lvl_prev <= lvl_cur;
    end
  end
endmodule

// File: rtl/gpio_style_det.sv
module gpio_style_det
  import gpio_style_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int STYLE_W = 3
) (
  input  logic [NPINS*STYLE_W-1:0] style_flat,
  input  logic [NPINS-1:0]         lvl_cur,
  input  logic [NPINS-1:0]         lvl_prev,
  output logic [NPINS-1:0]         hit
);
  for (genvar i = 0; i < NPINS; i++) begin : g_line
    logic [STYLE_W-1:0] sty;
    logic               hit_b;
    assign sty = style_flat[i*STYLE_W +: STYLE_W];

    always_comb begin
      case (sty)
        STY_HIGH: hit_b = lvl_cur[i];
        STY_LOW:  hit_b = !lvl_cur[i];
        STY_RISE: hit_b = lvl_cur[i] && !lvl_prev[i];
        STY_FALL: hit_b = !lvl_cur[i] && lvl_prev[i];
        STY_BOTH: hit_b = lvl_cur[i] ^ lvl_prev[i];
        default:  hit_b = 1'b0;
      endcase
    end
    assign hit[i] = hit_b;
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_style_pkg::*;
#(
  parameter int NPINS      = 16,
  parameter int STYLE_W    = 3,
  parameter int FIELD_BITS = (NPINS / 2) * STYLE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [BUS_AW-1:0]        addr,
  input  logic [FIELD_BITS-1:0]    wdata,
  output logic [NPINS-1:0]         dir_q,
  output logic [NPINS-1:0]         dout_q,
  output logic [NPINS*STYLE_W-1:0] style_q
);
  logic [NPINS-1:0]         dir_d, dout_d;
  logic [NPINS*STYLE_W-1:0] style_d;
  logic                     dir_en, dout_en, sty0_en, sty1_en;

  assign dir_en  = wr && (addr == A_DIR);
  assign dout_en = wr && (addr == A_DOUT);
  assign sty0_en = wr && (addr == A_STY0);
  assign sty1_en = wr && (addr == A_STY1);

  always_comb begin
    dir_d   = dir_q;
    dout_d  = dout_q;
    style_d = style_q;
    if (dir_en)  dir_d  = wdata[NPINS-1:0];
    if (dout_en) dout_d = wdata[NPINS-1:0];
    if (sty0_en) style_d[FIELD_BITS-1:0] = wdata;
    if (sty1_en) style_d[2*FIELD_BITS-1:FIELD_BITS] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      dout_q  <= '0;
      style_q <= '1;
    end else begin
      dir_q   <= dir_d;
      dout_q  <= dout_d;
      style_q <= style_d;
    end
  end
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend
  import gpio_style_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BUS_AW-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  hit,
  output logic [NPINS-1:0]  pend_q
);
  logic [NPINS-1:0] clr, pend_d;

  assign clr = (wr && (addr == A_STAT)) ? wdata : '0;

  // A detection in the same cycle wins over a clear.
  always_comb pend_d = (pend_q & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/gpio_irq_style_unit.sv
module gpio_irq_style_unit
  import gpio_style_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int STYLE_W = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  irq
);
  localparam int HALF       = NPINS / 2;
  localparam int FIELD_BITS = HALF * STYLE_W;

  logic [1:0]               rst_pipe;
  logic                     rst_core_n;
  logic [NPINS-1:0]         lvl_cur, lvl_prev, det_hit, dir_q, dout_q;
  logic [NPINS*STYLE_W-1:0] style_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .pad_in(pad_in),
    .lvl_cur(lvl_cur), .lvl_prev(lvl_prev)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .STYLE_W(STYLE_W), .FIELD_BITS(FIELD_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[FIELD_BITS-1:0]),
    .dir_q(dir_q), .dout_q(dout_q), .style_q(style_flat)
  );

  gpio_style_det #(.NPINS(NPINS), .STYLE_W(STYLE_W)) u_det (
    .style_flat(style_flat), .lvl_cur(lvl_cur), .lvl_prev(lvl_prev), .hit(det_hit)
  );

  gpio_pend #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_core_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[NPINS-1:0]), .hit(det_hit), .pend_q(irq)
  );

  assign pad_out = dout_q;
  assign pad_oe  = ~dir_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIR:   bus_rdata[NPINS-1:0]      = dir_q;
      A_DOUT:  bus_rdata[NPINS-1:0]      = dout_q;
      A_DIN:   bus_rdata[NPINS-1:0]      = lvl_cur;
      A_STY0:  bus_rdata[FIELD_BITS-1:0] = style_flat[FIELD_BITS-1:0];
      A_STY1:  bus_rdata[FIELD_BITS-1:0] = style_flat[2*FIELD_BITS-1:FIELD_BITS];
      A_STAT:  bus_rdata[NPINS-1:0]      = irq;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_style_chk.sv
module gpio_irq_style_chk
  import gpio_style_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int STYLE_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [BUS_AW-1:0]        bus_addr,
  input logic [NPINS-1:0]         wdata,
  input logic [NPINS-1:0]         irq,
  input logic [NPINS-1:0]         pad_out,
  input logic [NPINS-1:0]         hit,
  input logic [NPINS*STYLE_W-1:0] style_flat
);
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT) |=> ((irq & $past(wdata) & ~$past(hit)) == '0));

  // R12
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_STAT) |=> (($past(irq) & ~irq) == '0));

  // R10
  hit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((irq & $past(hit)) == $past(hit)));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_DOUT) |=> $stable(pad_out));

  for (genvar i = 0; i < NPINS; i++) begin : g_off
    // R8
    off_style_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style_flat[i*STYLE_W +: STYLE_W] > STY_BOTH) |-> !hit[i]);
  end
endmodule

bind gpio_irq_style_unit gpio_irq_style_chk #(.NPINS(NPINS), .STYLE_W(STYLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata(bus_wdata[NPINS-1:0]), .irq(irq), .pad_out(pad_out),
  .hit(det_hit), .style_flat(style_flat)
);

// File: tb/sim_gpio_irq_style_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_style_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pad_in, pad_out, pad_oe, irq;
  int          nchk = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_style_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string style_tag(input int s);
    if (s < 2) return "R5";
    if (s < 4) return "R6";
    if (s == 4) return "R7";
    return "R8";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic        e1, e2, e3, e4;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    check("R1 irq", {16'h0, irq}, 32'h0);
    rd(3'd0, d); check("R1 dir", d, 32'h0000FFFF);
    rd(3'd3, d); check("R1 style0", d, 32'h00FFFFFF);
    rd(3'd4, d); check("R1 style1", d, 32'h00FFFFFF);

    // R2 direction and output data
    wr(3'd0, 32'hABCD00F0);
    check("R2 pad_oe", {16'h0, pad_oe}, 32'h0000FF0F);
    rd(3'd0, d); check("R2 dir readback", d, 32'h000000F0);
    wr(3'd1, 32'h1234A5C3);
    check("R2 pad_out", {16'h0, pad_out}, 32'h0000A5C3);
    rd(3'd1, d); check("R2 dout readback", d, 32'h0000A5C3);

    // R4 packing readback
    wr(3'd3, 32'hFFFAC688);
    rd(3'd3, d); check("R4 style0 readback", d, 32'h00FAC688);
    wr(3'd4, 32'h12345678);
    rd(3'd4, d); check("R4 style1 readback", d, 32'h00345678);

    // Sweep every line and every style code
    for (int pin = 0; pin < 16; pin++) begin
      for (int s = 0; s < 8; s++) begin
        lo = 32'h00FFFFFF; hi = 32'h00FFFFFF;
        if (pin < 8) lo[3*pin +: 3] = 3'(s);
        else         hi[3*(pin-8) +: 3] = 3'(s);
        pad_in = '0;
        wr(3'd3, lo); wr(3'd4, hi);
        tick(4);
        wr(3'd5, 32'h0000FFFF);
        e1 = (s == 1);
        check({style_tag(s), " R10 R4 idle low"}, {16'h0, irq}, 32'(e1) << pin);
        pad_in[pin] = 1'b1;
        tick(4);
        e2 = e1 || s == 0 || s == 2 || s == 4;
        check({style_tag(s), " R4 after rise"}, {16'h0, irq}, 32'(e2) << pin);
        wr(3'd5, 32'(1) << pin);
        e3 = (s == 0);
        check({style_tag(s), " R9 R10 clear high"}, {16'h0, irq}, 32'(e3) << pin);
        pad_in[pin] = 1'b0;
        tick(4);
        e4 = e3 || s == 1 || s == 3 || s == 4;
        check({style_tag(s), " R4 after fall"}, {16'h0, irq}, 32'(e4) << pin);
        rd(3'd5, d); check("R12 status readback", d, 32'(e4) << pin);
      end
    end

    // R13 and R3 latency on line 5, rising style
    wr(3'd4, 32'h00FFFFFF);
    wr(3'd3, 32'h00FFFFFF & ~(32'h7 << 15) | (32'h2 << 15));
    tick(2);
    wr(3'd5, 32'h0000FFFF);
    check("R13 cleared", {16'h0, irq}, 32'h0);
    pad_in[5] = 1'b1;
    tick(1);
    rd(3'd2, d); check("R3 input after one edge", d, 32'h0);
    tick(1);
    check("R13 irq after two edges", {16'h0, irq}, 32'h0);
    rd(3'd2, d); check("R3 input after two edges", d, 32'h00000020);
    tick(1);
    check("R13 irq after three edges", {16'h0, irq}, 32'h00000020);

    // R9 zero writes leave pending bits alone
    wr(3'd5, 32'h0000FFDF);
    check("R9 zero bit kept", {16'h0, irq}, 32'h00000020);

    // R11 style rewrite keeps pending bit
    wr(3'd3, 32'h00FFFFFF & ~(32'h7 << 15) | (32'h3 << 15));
    tick(2);
    check("R11 pending after restyle", {16'h0, irq}, 32'h00000020);
    wr(3'd5, 32'h00000020);
    check("R9 cleared after restyle", {16'h0, irq}, 32'h0);

    // R12 sticky after pad returns with no matching style
    wr(3'd3, 32'h00FFFFFF & ~(32'h7 << 15) | (32'h4 << 15));
    pad_in[5] = 1'b0;
    tick(4);
    wr(3'd3, 32'h00FFFFFF);
    tick(4);
    check("R12 sticky", {16'h0, irq}, 32'h00000020);

    finish_run();
  end
endmodule